// File: doc/BRIEF.md
# Run-Length Symbol-to-Bit Aggregator

The aggregator sits after an FSK slicer that has already turned each carrier period into a single binary symbol. It counts how many equal symbols arrive in a row. When the symbol value flips, it turns the length of the finished run into a number of data bits and then emits that many copies of the run's value on its output stream. The symbols-per-bit divisor is chosen by the value of the run that just ended, so runs of ones and runs of zeros can use different rates. A run whose bit count is implausibly large is dropped without any output, which rejects noise and long idle stretches. Locating frames and decoding the bits are left to the logic downstream.

Three settings come from outside and may be changed between captures: the divisor for runs of ones, the divisor for runs of zeros, and the bit-count limit. The symbol input uses a valid/ready handshake. The bit output is a plain valid/data stream. A capture begins at reset. The run still open when the stream stops is never converted into bits.

Top module: `rl_run_aggregator`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The first run after reset is counted from 1 on its first symbol, so a first run of L symbols yields floor((L+1)/d) bits.
- R3: Every later run starts counting from 0 on its first symbol, so a run of L symbols yields floor(L/d) bits.
- R4: A run of ones (value 1) is divided by cfg_ones_div and a run of zeros (value 0) by cfg_zeros_div; both must lie in 2..15.
- R5: When the truncated quotient is 0, the count is forced to 1.
- R6: Bits are emitted only when the count is strictly less than cfg_bit_limit; otherwise the run produces no output at all.
- R7: Every bit of a burst carries the value of the run that just ended, one bit per cycle with out_valid high.
- R8: A run is converted only when a symbol of the opposite value is accepted; the open run at the end of the stream never produces output.
- R9: From the accepted symbol that ends a run until the last bit of its burst, in_ready stays 0, so out_valid and in_ready are never high together.
- R10: The run counter saturates at 2^CNTW-1 (255 by default), so the numerator of a long run is capped at 2^CNTW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a new capture |
| cfg_ones_div | input | 4 | Symbols per bit for runs of ones (2..15) |
| cfg_zeros_div | input | 4 | Symbols per bit for runs of zeros (2..15) |
| cfg_bit_limit | input | MAXW | Exclusive upper bound on bits emitted per run |
| in_valid | input | 1 | Symbol present |
| in_sym | input | 1 | Symbol value |
| in_ready | output | 1 | Symbol accepted at the next edge when high together with in_valid |
| out_valid | output | 1 | Output bit present |
| out_bit | output | 1 | Output bit value |

## Verification
A corrupted run counter or last-value register does not fail at once. It shows up only at the next opposite symbol, as a burst of the wrong length or the wrong polarity, or as a burst that is missing or should not be there. The bench therefore compares the whole output bit sequence of each capture against a model of the counting rules. A slip in the divider or the burst counter shows within the same burst, either as extra or missing bits or as in_ready rising while out_valid is still high. The checker detects the second case on the cycle it happens.

// File: rtl/rl_aggr_pkg.sv
package rl_aggr_pkg;
   localparam int DIV_W = 4;
   typedef logic [DIV_W-1:0] divisor_t;
   typedef enum logic {DIV_ITERATIVE, DIV_ONESHOT} div_style_e;
endpackage

// File: rtl/rl_run_tracker.sv
module rl_run_tracker #(
   parameter int CNTW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic            sym,
   output logic            run_end,
   output logic [CNTW:0]   end_len,
   output logic            end_val
);
   localparam logic [CNTW-1:0] CNT_MAX = {CNTW{1'b1}};

   logic            seen_q;
   logic            last_q;
   logic [CNTW-1:0] cnt_q;

   assign run_end = accept && seen_q && (sym != last_q);
   assign end_len = {1'b0, cnt_q} + 1'b1;
   assign end_val = last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept) begin
         if (!seen_q) begin
            seen_q <= 1'b1;
            last_q <= sym;
            cnt_q  <= CNTW'(1);
         end else if (sym != last_q) begin
            last_q <= sym;
            cnt_q  <= '0;
         end else if (cnt_q != CNT_MAX) begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rl_divider.sv
module rl_divider
   import rl_aggr_pkg::*;
#(
   parameter int         NW    = 9,
   parameter div_style_e STYLE = DIV_ITERATIVE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  divisor_t      den,
   output logic          busy,
   output logic          done,
   output logic [NW-1:0] quo
);
   if (STYLE == DIV_ONESHOT) begin : g_oneshot
      logic          done_q;
      logic [NW-1:0] quo_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            done_q <= 1'b0;
            quo_q  <= '0;
         end else begin
            done_q <= start;
            if (start)
               quo_q <= (den == '0) ? {NW{1'b1}} : num / NW'(den);
         end
      end
      assign busy = 1'b0;
      assign done = done_q;
      assign quo  = quo_q;
   end else begin : g_iterative
      localparam int SW = $clog2(NW);
      logic [DIV_W:0]  rem_q;
      logic [NW-1:0]   q_q;
      divisor_t        den_q;
      logic [SW-1:0]   step_q;
      logic            run_q;
      logic            done_q;
      logic [DIV_W:0]  trial;
      logic            fits;

      assign trial = {rem_q[DIV_W-1:0], q_q[NW-1]};
      assign fits  = trial >= {1'b0, den_q};

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rem_q  <= '0;
            q_q    <= '0;
            den_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
         end else if (start) begin
            rem_q  <= '0;
            q_q    <= num;
            den_q  <= den;
            step_q <= '0;
            run_q  <= 1'b1;
            done_q <= 1'b0;
         end else if (run_q) begin
            rem_q  <= fits ? trial - {1'b0, den_q} : trial;
            q_q    <= {q_q[NW-2:0], fits};
            step_q <= step_q + 1'b1;
            run_q  <= (step_q != SW'(NW-1));
            done_q <= (step_q == SW'(NW-1));
         end else begin
            done_q <= 1'b0;
         end
      end
      assign busy = run_q;
      assign done = done_q;
      assign quo  = q_q;
   end
endmodule

// File: rtl/rl_burst_emitter.sv
module rl_burst_emitter #(
   parameter int NW   = 9,
   parameter int MAXW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [NW-1:0]   quo,
   input  logic [MAXW-1:0] limit,
   input  logic            val,
   output logic            out_valid,
   output logic            out_bit
);
   localparam int CW = NW + MAXW;

   logic [NW-1:0] left_q;
   logic          val_q;
   logic [NW-1:0] bits;
   logic          allow;

   assign bits  = (quo == '0) ? NW'(1) : quo;
   assign allow = CW'(bits) < CW'(limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         val_q  <= 1'b0;
      end else if (load) begin
         left_q <= allow ? bits : '0;
         val_q  <= val;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign out_valid = (left_q != '0);
   assign out_bit   = val_q;
endmodule

// File: rtl/rl_run_aggregator.sv
module rl_run_aggregator
   import rl_aggr_pkg::*;
#(
   parameter int         CNTW      = 8,
   parameter int         MAXW      = 6,
   parameter div_style_e DIV_STYLE = DIV_ITERATIVE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      cfg_ones_div,
   input  logic [3:0]      cfg_zeros_div,
   input  logic [MAXW-1:0] cfg_bit_limit,
   input  logic            in_valid,
   input  logic            in_sym,
   output logic            in_ready,
   output logic            out_valid,
   output logic            out_bit
);
   localparam int NW = CNTW + 1;

   if (CNTW < 2 || CNTW > 14) begin : g_bad_cntw
      $error("rl_run_aggregator: CNTW must be in 2..14");
   end
   if (MAXW < 1 || MAXW > 16) begin : g_bad_maxw
      $error("rl_run_aggregator: MAXW must be in 1..16");
   end

   logic          accept;
   logic          run_end;
   logic [NW-1:0] end_len;
   logic          end_val;
   logic          div_busy;
   logic          div_done;
   logic [NW-1:0] div_quo;
   logic          run_val_q;
   divisor_t      den;

   assign accept   = in_valid && in_ready;
   assign in_ready = !(div_busy || div_done || out_valid);
   assign den      = end_val ? cfg_ones_div : cfg_zeros_div;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_val_q <= 1'b0;
      else if (run_end)
         run_val_q <= end_val;
   end

   rl_run_tracker #(.CNTW(CNTW)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .sym     (in_sym),
      .run_end (run_end),
      .end_len (end_len),
      .end_val (end_val)
   );

   rl_divider #(.NW(NW), .STYLE(DIV_STYLE)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (run_end),
      .num   (end_len),
      .den   (den),
      .busy  (div_busy),
      .done  (div_done),
      .quo   (div_quo)
   );

   rl_burst_emitter #(.NW(NW), .MAXW(MAXW)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (div_done),
      .quo       (div_quo),
      .limit     (cfg_bit_limit),
      .val       (run_val_q),
      .out_valid (out_valid),
      .out_bit   (out_bit)
   );
endmodule

// File: rtl/rl_run_aggregator_chk.sv
module rl_run_aggregator_chk #(
   parameter int MAXW = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic [3:0]      cfg_ones_div,
   input logic [3:0]      cfg_zeros_div,
   input logic [MAXW-1:0] cfg_bit_limit,
   input logic            in_valid,
   input logic            in_ready,
   input logic            out_valid,
   input logic            out_bit
);
   logic [9:0] burst_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         burst_q <= '0;
      else if (!out_valid)
         burst_q <= '0;
      else if (burst_q != 10'h3FF)
         burst_q <= burst_q + 1'b1;
   end

   assert_idle_after_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (in_ready && !out_valid));

   assert_no_intake_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   assert_burst_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> (out_bit == $past(out_bit)));

   assert_burst_under_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(burst_q) + 1 < int'(cfg_bit_limit)));

   assert_divisor_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (cfg_ones_div >= 4'd2 && cfg_zeros_div >= 4'd2));
endmodule

bind rl_run_aggregator rl_run_aggregator_chk #(.MAXW(MAXW)) u_chk (.*);

// File: tb/rl_run_aggregator_tb.sv
`timescale 1ns/1ps
module rl_run_aggregator_tb;
   localparam int CNTW = 8;
   localparam int MAXW = 6;
   localparam int CSAT = (1 << CNTW) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      d1 = 4'd6;
   logic [3:0]      d0 = 4'd5;
   logic [MAXW-1:0] lim = 6'd5;
   logic            in_valid = 1'b0;
   logic            in_sym = 1'b0;
   logic            in_ready, out_valid, out_bit;

   always #2.5 clk = ~clk;

   rl_run_aggregator #(.CNTW(CNTW), .MAXW(MAXW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_ones_div(d1), .cfg_zeros_div(d0),
      .cfg_bit_limit(lim), .in_valid(in_valid), .in_sym(in_sym),
      .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit));

   int checks = 0, errors = 0, overlaps = 0;
   bit done_flag = 0;
   bit got[$];
   bit expq[$];
   bit m_seen, m_last;
   int m_cnt;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) got.push_back(out_bit);
         if (out_valid && in_ready) overlaps++;
      end
   end

   function automatic int nbits(int c, int d);
      int q;
      q = (c + 1) / d;
      if (q == 0) q = 1;
      return q;
   endfunction

   task automatic model(bit s);
      int n;
      if (!m_seen) begin
         m_seen = 1; m_last = s; m_cnt = 1;
      end else if (s != m_last) begin
         n = nbits(m_cnt, m_last ? int'(d1) : int'(d0));
         if (n < int'(lim)) repeat (n) expq.push_back(m_last);
         m_last = s; m_cnt = 0;
      end else if (m_cnt < CSAT) begin
         m_cnt++;
      end
   endtask

   task automatic do_reset(int a1, int a0, int al);
      in_valid = 0;
      rst_n = 0;
      d1 = 4'(a1); d0 = 4'(a0); lim = MAXW'(al);
      repeat (3) @(negedge clk);
      got.delete(); expq.delete();
      m_seen = 0; m_last = 0; m_cnt = 0;
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic send(bit s, int gap);
      in_valid = 1; in_sym = s;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      model(s);
      in_valid = 0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic send_run(bit s, int len);
      repeat (len) send(s, 0);
   endtask

   task automatic compare(string tag, int lit);
      int bad;
      while (!in_ready) @(negedge clk);
      repeat (20) @(negedge clk);
      checks++;
      if (got.size() != expq.size()) begin
         errors++;
         $display("FAIL %s bit count: actual %0d expected %0d", tag, got.size(), expq.size());
      end
      if (lit >= 0) begin
         checks++;
         if (got.size() != lit) begin
            errors++;
            $display("FAIL %s fixed count: actual %0d expected %0d", tag, got.size(), lit);
         end
      end
      checks++;
      bad = -1;
      for (int i = 0; i < got.size() && i < expq.size(); i++)
         if (bad < 0 && got[i] != expq[i]) bad = i;
      if (bad >= 0) begin
         errors++;
         $display("FAIL %s R7 bit %0d: actual %0b expected %0b", tag, bad, got[bad], expq[bad]);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      do_reset(6, 5, 5);
      checks++;
      if (!(in_ready === 1'b1 && out_valid === 1'b0)) begin
         errors++;
         $display("FAIL R1 idle: actual ready=%b valid=%b expected ready=1 valid=0", in_ready, out_valid);
      end

      // R2: first run 5 ones -> (5+1)/6 = 1; zeros 10 -> 10/5 = 2; tail ones unflushed
      do_reset(6, 5, 5);
      send_run(1, 5); send_run(0, 10); send_run(1, 3);
      compare("R2 first-run", 3);

      // R3 and R5: later runs count from zero; short runs forced to one bit
      do_reset(6, 5, 5);
      send_run(0, 1); send_run(1, 2); send_run(0, 15); send_run(1, 1);
      compare("R3 R5 short-runs", 5);

      // R6: first ones run gives 31/6 = 5, not below limit 5 -> dropped
      do_reset(6, 5, 5);
      send_run(1, 30); send_run(0, 20); send_run(1, 1);
      compare("R6 limit", 4);

      // R4: ones use 7, zeros use 6; swapping would change the count
      do_reset(7, 6, 13);
      send_run(0, 3); send_run(1, 14); send_run(0, 12); send_run(1, 1);
      compare("R4 divisor-select", 5);

      // R8: a single open run never flushes
      do_reset(6, 5, 5);
      send_run(1, 40);
      compare("R8 no-flush", 0);

      // R10: 400 zeros saturate at 255 -> 256/5 = 51 bits
      do_reset(6, 5, 63);
      send_run(1, 2); send_run(0, 400); send_run(1, 1);
      compare("R10 saturate", 52);

      // Constrained random captures, including both standard settings
      for (int k = 0; k < 6; k++) begin
         if (k == 0) do_reset(6, 5, 5);
         else if (k == 1) do_reset(7, 6, 13);
         else do_reset(2 + int'($urandom_range(13)), 2 + int'($urandom_range(13)),
                       1 + int'($urandom_range(62)));
         for (int r = 0; r < 30; r++) begin
            int len;
            len = 1 + int'($urandom_range(39));
            for (int j = 0; j < len; j++) send(bit'(r & 1), int'($urandom_range(2)));
         end
         compare("R3 R4 R6 random", -1);
      end

      checks++;
      if (overlaps != 0) begin
         errors++;
         $display("FAIL R9 stall: actual %0d overlap cycles expected 0", overlaps);
      end

      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule